// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Digital Lock Qualifier

This block compares the divided reference against the divided feedback and produces the two correction requests that steer a synthesizer loop. The reference input `fr` first passes through a 6-bit programmable divider, which emits one comparison tick for every R+1 rising edges. With R = 0 every reference edge becomes a tick. The feedback input `fp` arrives already divided. Both inputs are asynchronous to the system clock. Each one passes through a synchronizer and a rising-edge extractor before it reaches the detector.

A comparison tick sets the "raise frequency" flag and a feedback edge sets the "lower frequency" flag. When both flags are set, both are released after a fixed delay. The flags leave the block as the active-low pins `up_n` and `dn_n`. A pin is low for a time that grows with the phase offset between the two edges. `activity` is the NAND of the two pins, so it is high while either pin is low.

A counter on the system clock replaces an external integrating capacitor and qualifies lock. Lock is declared once enough consecutive comparison intervals contain only short activity runs. Lock is lost as soon as one run grows too long. An output-enable input and a power-down input hold both pins inactive.

Top module: `phase_detect_lock`

## Requirements
- R1: `fc_tick` is high for one clock on every (R+1)-th synchronized rising edge of `fr` after reset, where R is the effective divide setting taken from `r_div`. The first tick comes on edge number R+1. With R = 0, every edge gives a tick.
- R2: While `dir_mode` is 1, bits 5 and 4 of `r_div` are treated as 0, so the effective R is `r_div[3:0]`.
- R3: A comparison tick drives `up_n` low and a rising edge of `fp` drives `dn_n` low. Falling edges of either input have no effect. After reset both pins are 1, and `activity`, `locked` and `fc_tick` are 0.
- R4: Both inputs pass through the same two-stage synchronizer. With RST_DLY = 1, if the feedback edge lags the reference edge by d input cycles, `up_n` is low for d+1 clocks and `dn_n` for 1 clock. If the feedback edge leads by d cycles, `dn_n` is low for d+1 clocks and `up_n` for 1 clock.
- R5: Once both flags are set, both are released after exactly RST_DLY clocks (default 1). If the two edges fall in the same clock, both pins are low together for exactly RST_DLY clocks.
- R6: `activity` equals the NAND of `up_n` and `dn_n` in every cycle.
- R7: `locked` rises only in the clock after a comparison tick. It rises at the 16th consecutive tick whose preceding interval held no activity run of `lock_win` clocks or longer. With `lock_win` = 4, a run of 3 clocks is acceptable.
- R8: When an activity run reaches `lock_win` clocks, `locked` falls at the next clock edge and the count of good intervals restarts. With `lock_win` = 4, a run of 4 clocks drops lock.
- R9: While `out_en` is 0, `up_n` and `dn_n` stay 1 and `activity` stays 0. The divider keeps producing `fc_tick`.
- R10: While `pwr_dn` is 1, both pins stay 1, both flags are cleared, and `locked` is 0 from the clock after `pwr_dn` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fr | input | 1 | Reference input, asynchronous |
| fp | input | 1 | Divided feedback input, asynchronous |
| r_div | input | 6 | Reference divide setting R (ratio R+1) |
| dir_mode | input | 1 | Forces the two upper divide bits to zero |
| out_en | input | 1 | Enables the correction pins |
| pwr_dn | input | 1 | Powers down the detector and the lock logic |
| lock_win | input | 6 | Activity run length, in clocks, that counts as out of lock |
| up_n | output | 1 | Raise-frequency request, active low |
| dn_n | output | 1 | Lower-frequency request, active low |
| activity | output | 1 | NAND of `up_n` and `dn_n` |
| fc_tick | output | 1 | One-clock comparison tick from the reference divider |
| locked | output | 1 | Qualified lock indication |

## Verification
Three events can fall into one clock: a comparison tick, a feedback edge, and the lock tally. The bench provokes coincidence by driving `fr` and `fp` with zero offset. It judges that case by counting exactly one low clock on each pin, and by the assertion that limits how long both pins may stay low together. An offset sweep from -4 to +4 checks every pulse width and the `activity` level against counts computed from the offset. The lock tests use offsets either side of the `lock_win` boundary, so that a violation and a tick in the same interval resolve to a lost lock.

// File: rtl/phase_detect_lock_pkg.sv
package phase_detect_lock_pkg;
  localparam int unsigned PDL_RDIV_W   = 6;
  localparam int unsigned PDL_DIR_KEEP = 4;
  localparam int unsigned PDL_SYNC     = 2;
  localparam int unsigned PDL_RST_DLY  = 1;
  localparam int unsigned PDL_WIN_W    = 6;
  localparam int unsigned PDL_LOCK_CYC = 16;

  typedef enum logic [0:0] {
    SRC_REF = 1'b0,
    SRC_FB  = 1'b1
  } pdl_src_e;

  typedef struct packed {
    logic raise;
    logic lower;
  } pdl_flags_t;
endpackage

// File: rtl/pdl_edge_sync.sv
module pdl_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pdl_ref_div.sv
module pdl_ref_div #(
  parameter int unsigned RDIV_W   = 6,
  parameter int unsigned DIR_KEEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ref_rise,
  input  logic [RDIV_W-1:0] r_div,
  input  logic              dir_mode,
  output logic              tick
);
  localparam int unsigned FORCED_W = RDIV_W - DIR_KEEP;

  logic [RDIV_W-1:0] r_eff;
  logic [RDIV_W-1:0] cnt;
  logic              wrap;

  generate
    if (FORCED_W > 0) begin : g_forced
      assign r_eff = dir_mode ? {{FORCED_W{1'b0}}, r_div[DIR_KEEP-1:0]} : r_div;
    end else begin : g_plain
      assign r_eff = r_div;
    end
  endgenerate

  assign wrap = (cnt >= r_eff);
  assign tick = ref_rise & wrap & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (ref_rise) cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/pdl_flags.sv
module pdl_flags
  import phase_detect_lock_pkg::*;
#(
  parameter int unsigned RST_DLY = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       set_raise,
  input  logic       set_lower,
  output pdl_flags_t flags
);
  localparam int unsigned DLY_W = (RST_DLY < 2) ? 1 : $clog2(RST_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(RST_DLY - 1);

  logic [DLY_W-1:0] dly;
  logic             both;
  logic             release_now;

  assign both        = flags.raise & flags.lower;
  assign release_now = both & (dly == DLY_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      dly   <= '0;
    end else if (clr) begin
      flags <= '0;
      dly   <= '0;
    end else begin
      flags.raise <= (flags.raise & ~release_now) | set_raise;
      flags.lower <= (flags.lower & ~release_now) | set_lower;
      dly         <= (both & ~release_now) ? dly + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/pdl_lock_qual.sv
module pdl_lock_qual #(
  parameter int unsigned WIN_W    = 6,
  parameter int unsigned LOCK_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             act,
  input  logic             tick,
  input  logic [WIN_W-1:0] win,
  output logic             locked
);
  localparam int unsigned CNT_W = $clog2(LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOCK_CYC);

  logic [WIN_W-1:0] run_len;
  logic [CNT_W-1:0] good;
  logic             dirty;
  logic             viol;
  logic [WIN_W:0]   run_next;

  assign run_next = {1'b0, run_len} + 1'b1;
  assign viol     = act & (run_next >= {1'b0, win});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      good    <= '0;
      dirty   <= 1'b0;
      locked  <= 1'b0;
    end else if (clr) begin
      run_len <= '0;
      good    <= '0;
      dirty   <= 1'b0;
      locked  <= 1'b0;
    end else begin
      if (!act)                  run_len <= '0;
      else if (!(&run_len))      run_len <= run_len + 1'b1;

      if (viol) begin
        dirty  <= 1'b1;
        good   <= '0;
        locked <= 1'b0;
      end else if (tick) begin
        dirty <= 1'b0;
        if (!dirty) begin
          if (good < CNT_TOP) good <= good + 1'b1;
          if (good + 1'b1 >= CNT_TOP) locked <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/phase_detect_lock.sv
module phase_detect_lock
  import phase_detect_lock_pkg::*;
#(
  parameter int unsigned RDIV_W   = PDL_RDIV_W,
  parameter int unsigned DIR_KEEP = PDL_DIR_KEEP,
  parameter int unsigned SYNC     = PDL_SYNC,
  parameter int unsigned RST_DLY  = PDL_RST_DLY,
  parameter int unsigned WIN_W    = PDL_WIN_W,
  parameter int unsigned LOCK_CYC = PDL_LOCK_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr,
  input  logic              fp,
  input  logic [RDIV_W-1:0] r_div,
  input  logic              dir_mode,
  input  logic              out_en,
  input  logic              pwr_dn,
  input  logic [WIN_W-1:0]  lock_win,
  output logic              up_n,
  output logic              dn_n,
  output logic              activity,
  output logic              fc_tick,
  output logic              locked
);
  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0] raw_in;
  logic [NSRC-1:0] rise;
  pdl_flags_t      flags;
  logic            drive_ok;

  assign raw_in[SRC_REF] = fr;
  assign raw_in[SRC_FB]  = fp;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_sync
      pdl_edge_sync #(.STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in[g]),
        .rise (rise[g])
      );
    end
  endgenerate

  pdl_ref_div #(.RDIV_W(RDIV_W), .DIR_KEEP(DIR_KEEP)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pwr_dn),
    .ref_rise(rise[SRC_REF]),
    .r_div   (r_div),
    .dir_mode(dir_mode),
    .tick    (fc_tick)
  );

  pdl_flags #(.RST_DLY(RST_DLY)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pwr_dn),
    .set_raise(fc_tick),
    .set_lower(rise[SRC_FB] & ~pwr_dn),
    .flags    (flags)
  );

  pdl_lock_qual #(.WIN_W(WIN_W), .LOCK_CYC(LOCK_CYC)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pwr_dn),
    .act   (flags.raise | flags.lower),
    .tick  (fc_tick),
    .win   (lock_win),
    .locked(locked)
  );

  assign drive_ok = out_en & ~pwr_dn;
  assign up_n     = ~(flags.raise & drive_ok);
  assign dn_n     = ~(flags.lower & drive_ok);
  assign activity = ~(up_n & dn_n);
endmodule

// File: rtl/phase_detect_lock_chk.sv
module phase_detect_lock_chk #(
  parameter int unsigned RST_DLY = 1
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_dn,
  input logic out_en,
  input logic up_n,
  input logic dn_n,
  input logic fc_tick,
  input logic locked
);
  logic [15:0] both_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 both_run <= '0;
    else if (!up_n && !dn_n) begin
      if (!(&both_run))         both_run <= both_run + 1'b1;
    end else                    both_run <= '0;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fc_tick |=> !fc_tick); // R1

  AST_BOTH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_n && !dn_n) |-> (both_run < 16'(RST_DLY))); // R5

  AST_LOCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(fc_tick)); // R7

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn || !out_en) |-> (up_n && dn_n)); // R9

  AST_PWRDN_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !locked); // R10
endmodule

bind phase_detect_lock phase_detect_lock_chk #(.RST_DLY(RST_DLY)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pwr_dn (pwr_dn),
  .out_en (out_en),
  .up_n   (up_n),
  .dn_n   (dn_n),
  .fc_tick(fc_tick),
  .locked (locked)
);

// File: tb/tb_phase_detect_lock.sv
module tb_phase_detect_lock;
  localparam int CLK_PERIOD = 10;
  localparam int PER  = 24;
  localparam int BASE = 4;
  localparam int HI   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fr = 1'b0;
  logic       fp = 1'b0;
  logic [5:0] r_div = '0;
  logic       dir_mode = 1'b0;
  logic       out_en = 1'b1;
  logic       pwr_dn = 1'b0;
  logic [5:0] lock_win = 6'd63;
  logic       up_n, dn_n, activity, fc_tick, locked;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_detect_lock dut (
    .clk(clk), .rst_n(rst_n), .fr(fr), .fp(fp), .r_div(r_div),
    .dir_mode(dir_mode), .out_en(out_en), .pwr_dn(pwr_dn),
    .lock_win(lock_win), .up_n(up_n), .dn_n(dn_n),
    .activity(activity), .fc_tick(fc_tick), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fr = 1'b0; fp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_period(input int off, output int up_lo, output int dn_lo,
                            output int act_hi, output int ticks, output int act_bad);
    up_lo = 0; dn_lo = 0; act_hi = 0; ticks = 0; act_bad = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (!up_n) up_lo++;
      if (!dn_n) dn_lo++;
      if (activity) act_hi++;
      if (fc_tick) ticks++;
      if (activity !== ~(up_n & dn_n)) act_bad++;
      fr = (i >= BASE) && (i < BASE + HI);
      fp = (i >= BASE + off) && (i < BASE + off + HI);
    end
  endtask

  task automatic count_ticks(input int n_edges, output int ticks);
    ticks = 0;
    for (int e = 0; e < n_edges; e++) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (fc_tick) ticks++;
        fr = (i < 2);
      end
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (fc_tick) ticks++;
      fr = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int up_lo, dn_lo, act_hi, ticks, act_bad;
    int e_up, e_dn, mag;

    do_reset();
    // R3 reset state
    chk(up_n && dn_n && !activity && !locked && !fc_tick, "R3 reset", {up_n, dn_n, activity, locked, fc_tick}, 5'b11000);

    // R1 sweep of every divide setting
    for (int r = 0; r < 64; r++) begin
      r_div = 6'(r);
      do_reset();
      count_ticks(2 * (r + 1) + r / 2, ticks);
      chk(ticks == 2, $sformatf("R1 div R=%0d", r), ticks, 2);
    end

    // R2 forced upper bits
    dir_mode = 1'b1;
    r_div = 6'h3F; do_reset(); count_ticks(32, ticks);
    chk(ticks == 2, "R2 dir 0x3F", ticks, 2);
    r_div = 6'h25; do_reset(); count_ticks(12, ticks);
    chk(ticks == 2, "R2 dir 0x25", ticks, 2);
    dir_mode = 1'b0;
    r_div = 6'h25; do_reset(); count_ticks(12, ticks);
    chk(ticks == 0, "R2 no dir 0x25", ticks, 0);

    // R4/R5/R6 offset sweep with R=0
    r_div = '0; lock_win = 6'd63;
    do_reset();
    for (int off = -4; off <= 4; off++) begin
      run_period(off, up_lo, dn_lo, act_hi, ticks, act_bad);
      mag  = (off < 0) ? -off : off;
      e_up = (off > 0) ? off + 1 : 1;
      e_dn = (off < 0) ? mag + 1 : 1;
      chk(up_lo == e_up, $sformatf("R4 up_n width off=%0d", off), up_lo, e_up);
      chk(dn_lo == e_dn, $sformatf("R4 dn_n width off=%0d", off), dn_lo, e_dn);
      chk(act_hi == mag + 1, $sformatf("R6 activity width off=%0d", off), act_hi, mag + 1);
      chk(act_bad == 0, $sformatf("R6 activity NAND off=%0d", off), act_bad, 0);
      chk(ticks == 1, $sformatf("R3 one tick off=%0d", off), ticks, 1);
      if (off == 0)
        chk(up_lo == 1 && dn_lo == 1, "R5 coincident edges", up_lo + dn_lo, 2);
    end

    // R7 lock acquisition with window 4, run of 3
    lock_win = 6'd4;
    do_reset();
    for (int p = 1; p <= 16; p++) begin
      run_period(2, up_lo, dn_lo, act_hi, ticks, act_bad);
      if (p == 15) chk(locked == 1'b0, "R7 not yet locked after 15", locked, 0);
      if (p == 16) chk(locked == 1'b1, "R7 locked after 16", locked, 1);
    end
    run_period(-2, up_lo, dn_lo, act_hi, ticks, act_bad);
    chk(locked == 1'b1, "R7 lock holds on run of 3", locked, 1);

    // R8 run of 4 drops lock
    run_period(3, up_lo, dn_lo, act_hi, ticks, act_bad);
    chk(locked == 1'b0, "R8 lock dropped on run of 4", locked, 0);

    // R9 outputs disabled
    out_en = 1'b0;
    run_period(3, up_lo, dn_lo, act_hi, ticks, act_bad);
    chk(up_lo == 0 && dn_lo == 0, "R9 pins quiet", up_lo + dn_lo, 0);
    chk(act_hi == 0, "R9 activity quiet", act_hi, 0);
    chk(ticks == 1, "R9 divider still ticks", ticks, 1);
    out_en = 1'b1;

    // R10 power down after lock
    do_reset();
    for (int p = 1; p <= 16; p++) run_period(1, up_lo, dn_lo, act_hi, ticks, act_bad);
    chk(locked == 1'b1, "R10 precondition locked", locked, 1);
    pwr_dn = 1'b1;
    @(negedge clk);
    chk(locked == 1'b0, "R10 unlock on power down", locked, 0);
    run_period(3, up_lo, dn_lo, act_hi, ticks, act_bad);
    chk(up_lo == 0 && dn_lo == 0 && act_hi == 0, "R10 pins quiet", up_lo + dn_lo + act_hi, 0);
    pwr_dn = 1'b0;
    run_period(2, up_lo, dn_lo, act_hi, ticks, act_bad);
    chk(up_lo == 3 && dn_lo == 1, "R10 detector resumes", up_lo * 10 + dn_lo, 31);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule